// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDR SDRAM interface. It takes the memory devices from power-up to normal operation. A single start pulse launches the sequence. The sequencer first waits for power and clocks to settle. It then runs a fixed series of device commands: a no-operation, a precharge of all banks, eight auto-refresh cycles and a mode-register load. A programmed wait follows each of these steps.

Each command is sent to one populated memory row at a time, lowest row first, through a per-row chip-select vector. Rows that are absent are skipped and cost no cycles. The row-population mask is captured when the start pulse arrives. The mode word goes onto the address lines pre-shifted, so that it survives a fixed 3-bit right shift in the downstream address path.

Once the last wait has elapsed, the controller enters normal mode for one cycle. Only then does it raise the refresh-enable flag, followed by the done flag.

Top module: `sdram_init_seq`

## Requirements
- R1: Whenever reset is high or no start pulse has been seen, every chip select is high, RAS#, CAS# and WE# are high, the address bus is zero, and refresh_en and done are low. Reset in the middle of a sequence returns the block to this idle state, and it stays there until the next start.
- R2: The cycle after the clock edge that samples start begins a power-settle period of CLK_KHZ*PWR_US/1000 cycles. During this period all chip selects stay high.
- R3: The steps run in this order: NOP, precharge-all, exactly 8 auto-refresh, mode-register set. Each command is issued for one cycle per populated row, in ascending row order, with only that row's chip select (cs_n bit equal to the row index) low. Rows whose mask bit is 0 are skipped and take no cycle.
- R4: Commands are encoded as {CS#,RAS#,CAS#,WE#}: NOP 0111, precharge-all 0010, auto-refresh 0001, mode-register set 0000. Precharge-all drives address bit 10 high and all other address bits low. NOP and auto-refresh drive the address bus to zero.
- R5: After the last row of a step comes a wait. Its length is NOP_WAIT cycles (default 200) after NOP, trp_cycles after precharge, trc_cycles after each auto-refresh, and 2 cycles after the mode-register set. A programmed value of 0 counts as 1. During a wait, NOP is driven: chip selects are low on the populated rows, RAS#, CAS# and WE# are high, and the address is zero.
- R6: During the mode-register set, the address equals the mode word shifted left by 3. The mode word has burst length code in bits 2:0 (parameter, default 3'b011), burst type in bit 3 (default 0), CAS latency 3 in bits 6:4, bits 8:7 at 0 and bit 9 at 0. With the defaults the address is 13'h198.
- R7: After the mode-register wait, there is one normal-mode cycle in which all chip selects are high and refresh_en is still low. refresh_en rises in the next cycle and done rises one cycle after that. Both stay high, with the bus deselected, until reset.
- R8: The row mask is sampled with the start pulse, and later changes to row_mask have no effect. With an empty mask, no command is issued and no chip select is ever low, but every wait still elapses with its full length.
- R9: A start pulse while the sequence is running, or after done, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| row_mask | input | NUM_ROWS | Populated-row mask, bit i for row i |
| trp_cycles | input | T_W | Wait after precharge-all, in cycles |
| trc_cycles | input | T_W | Wait after each auto-refresh, in cycles |
| cs_n | output | NUM_ROWS | Active-low per-row chip selects |
| ras_n | output | 1 | Active-low row address strobe |
| cas_n | output | 1 | Active-low column address strobe |
| we_n | output | 1 | Active-low write enable |
| addr | output | ADDR_W | Device address bus |
| refresh_en | output | 1 | Periodic refresh enable, sticky until reset |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
All outputs are decoded from registered state, so each value is due in a fixed cycle counted from the edge that samples start. The first power-settle cycle is the one that immediately follows that edge. Each command occupies exactly one cycle per populated row, and each wait occupies exactly its programmed count. The bench builds the expected schedule cycle by cycle from the requirements and compares all outputs at every falling edge from the first power-settle cycle until several cycles past done. This places every command, wait boundary, refresh_en edge and done edge at its exact cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Internal 3-bit command field
    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_MRS       = 3'd3,
        CMD_CBR       = 3'd4
    } init_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_CMD,
        ST_WAIT,
        ST_NORM,
        ST_REFON,
        ST_DONE
    } seq_state_e;

    localparam int CBR_COUNT   = 8;
    localparam int MRS_WAIT    = 2;
    localparam int MODE_SHIFT  = 3;
    localparam int PRE_ALL_BIT = 10;
    localparam int CAS_LAT     = 3;

    // {ras_n, cas_n, we_n} for a command; NORMAL never reaches the pins
    function automatic logic [2:0] cmd_pins(init_cmd_e c);
        case (c)
            CMD_PRECHARGE: return 3'b010;
            CMD_MRS:       return 3'b000;
            CMD_CBR:       return 3'b001;
            default:       return 3'b111;
        endcase
    endfunction

    // Unshifted 10-bit mode word
    function automatic logic [9:0] mode_word(logic [2:0] bl_code, logic bt);
        return {1'b0, 2'b00, 3'(CAS_LAT), bt, bl_code};
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign expired = (cnt_q == '0);

    // R5
    expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_row_pick.sv
module sdram_init_row_pick #(
    parameter int N  = 4,
    parameter int RW = 2,
    parameter int FW = 3
) (
    input  logic [N-1:0]  mask,
    input  logic [FW-1:0] from_idx,
    output logic          found,
    output logic [RW-1:0] idx
);
    // Lowest populated row at or above from_idx
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (FW'(i) >= from_idx)) begin
                found = 1'b1;
                idx   = RW'(i);
            end
        end
    end

    // R3
    always_comb begin
        pick_valid_chk: assert (!found || mask[idx]);
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int          NUM_ROWS         = 4,
    parameter int          ADDR_W           = 13,
    parameter int          T_W              = 8,
    parameter int          CLK_KHZ          = 66000,
    parameter int          PWR_US           = 200,
    parameter int          NOP_WAIT         = 200,
    parameter logic [2:0]  BURST_LEN_CODE   = 3'b011,
    parameter logic        BURST_INTERLEAVE = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NUM_ROWS-1:0] row_mask,
    input  logic [T_W-1:0]      trp_cycles,
    input  logic [T_W-1:0]      trc_cycles,
    output logic [NUM_ROWS-1:0] cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ADDR_W-1:0]   addr,
    output logic                refresh_en,
    output logic                done
);
    localparam int PWR_CYC = (CLK_KHZ * PWR_US) / 1000;
    localparam int MAXW_A  = (PWR_CYC > NOP_WAIT) ? PWR_CYC : NOP_WAIT;
    localparam int MAXW    = (MAXW_A > (1 << T_W)) ? MAXW_A : (1 << T_W);
    localparam int TW      = $clog2(MAXW + 1);
    localparam int RW      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int FW      = $clog2(NUM_ROWS + 1);
    localparam int CW      = $clog2(CBR_COUNT);
    localparam logic [ADDR_W-1:0] MODE_ADDR =
        ADDR_W'(mode_word(BURST_LEN_CODE, BURST_INTERLEAVE)) << MODE_SHIFT;
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

    seq_state_e          state_q, state_d;
    init_cmd_e           cmd_q, cmd_d, enter_cmd;
    logic [RW-1:0]       row_q, row_d;
    logic [CW-1:0]       cbr_q, cbr_d;
    logic [NUM_ROWS-1:0] mask_q;
    logic                ref_q, done_q;
    logic                enter;
    logic                tmr_load, tmr_exp;
    logic [TW-1:0]       tmr_val;
    logic                first_found, nxt_found;
    logic [RW-1:0]       first_idx, nxt_idx;

    // Wait length minus one for the step that just issued command c
    function automatic logic [TW-1:0] wait_of(init_cmd_e c,
                                              logic [T_W-1:0] p,
                                              logic [T_W-1:0] r);
        case (c)
            CMD_NOP:       return TW'(NOP_WAIT - 1);
            CMD_PRECHARGE: return (p == '0) ? '0 : TW'(p) - TW'(1);
            CMD_CBR:       return (r == '0) ? '0 : TW'(r) - TW'(1);
            default:       return TW'(MRS_WAIT - 1);
        endcase
    endfunction

    sdram_init_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdram_init_row_pick #(.N(NUM_ROWS), .RW(RW), .FW(FW)) i_pick_first (
        .mask     (mask_q),
        .from_idx (FW'(0)),
        .found    (first_found),
        .idx      (first_idx)
    );

    sdram_init_row_pick #(.N(NUM_ROWS), .RW(RW), .FW(FW)) i_pick_next (
        .mask     (mask_q),
        .from_idx (FW'(row_q) + FW'(1)),
        .found    (nxt_found),
        .idx      (nxt_idx)
    );

    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        row_d     = row_q;
        cbr_d     = cbr_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        enter     = 1'b0;
        enter_cmd = cmd_q;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_PWR;
                tmr_load = 1'b1;
                tmr_val  = TW'(PWR_CYC - 1);
            end
            ST_PWR: if (tmr_exp) begin
                enter     = 1'b1;
                enter_cmd = CMD_NOP;
            end
            ST_CMD: begin
                if (nxt_found) begin
                    row_d = nxt_idx;
                end else begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = wait_of(cmd_q, trp_cycles, trc_cycles);
                end
            end
            ST_WAIT: if (tmr_exp) begin
                case (cmd_q)
                    CMD_NOP: begin
                        enter     = 1'b1;
                        enter_cmd = CMD_PRECHARGE;
                    end
                    CMD_PRECHARGE: begin
                        enter     = 1'b1;
                        enter_cmd = CMD_CBR;
                        cbr_d     = '0;
                    end
                    CMD_CBR: begin
                        enter = 1'b1;
                        if (cbr_q == CW'(CBR_COUNT - 1)) begin
                            enter_cmd = CMD_MRS;
                        end else begin
                            enter_cmd = CMD_CBR;
                            cbr_d     = cbr_q + CW'(1);
                        end
                    end
                    default: begin
                        state_d = ST_NORM;
                        cmd_d   = CMD_NORMAL;
                    end
                endcase
            end
            ST_NORM:  state_d = ST_REFON;
            ST_REFON: state_d = ST_DONE;
            default:  state_d = state_q;
        endcase
        if (enter) begin
            cmd_d = enter_cmd;
            if (first_found) begin
                state_d = ST_CMD;
                row_d   = first_idx;
            end else begin
                state_d  = ST_WAIT;
                tmr_load = 1'b1;
                tmr_val  = wait_of(enter_cmd, trp_cycles, trc_cycles);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NORMAL;
            row_q   <= '0;
            cbr_q   <= '0;
            mask_q  <= '0;
            ref_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            row_q   <= row_d;
            cbr_q   <= cbr_d;
            if (state_q == ST_IDLE && start)
                mask_q <= row_mask;
            if (state_q == ST_NORM)
                ref_q <= 1'b1;
            if (state_q == ST_REFON)
                done_q <= 1'b1;
        end
    end

    // Pin decode from registered state
    always_comb begin
        cs_n                 = '1;
        {ras_n, cas_n, we_n} = 3'b111;
        addr                 = '0;
        case (state_q)
            ST_CMD: begin
                cs_n                 = ~(NUM_ROWS'(1) << row_q);
                {ras_n, cas_n, we_n} = cmd_pins(cmd_q);
                if (cmd_q == CMD_PRECHARGE)
                    addr = PRE_ADDR;
                else if (cmd_q == CMD_MRS)
                    addr = MODE_ADDR;
            end
            ST_WAIT: cs_n = ~mask_q;
            default: ;
        endcase
    end

    assign refresh_en = ref_q;
    assign done       = done_q;

    // R3
    one_row_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(ras_n && cas_n && we_n) |-> ($countones(~cs_n) == 1));

    // R8
    mask_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((~cs_n & ~mask_q) == '0));

    // R6
    mode_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !cas_n && !we_n) |-> (addr == MODE_ADDR));

    // R7
    refresh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en |=> refresh_en);

    // R7
    done_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(refresh_en));

    // R7
    quiet_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en |-> (&cs_n));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 4;
    localparam int AW         = 13;
    localparam int PWR_CYC    = 40;   // 1000 kHz * 40 us / 1000
    localparam int NOPW       = 200;
    localparam int MAXLEN     = 2048;
    localparam int NVEC       = 5;

    // {mask[3:0], trp[7:0], trc[7:0], disturb[3:0]}
    localparam logic [23:0] VECS [NVEC] = '{
        {4'b1111, 8'd3, 8'd7, 4'h0},
        {4'b0101, 8'd0, 8'd1, 4'h0},
        {4'b1000, 8'd5, 8'd2, 4'h1},
        {4'b0000, 8'd2, 8'd3, 4'h0},
        {4'b0110, 8'd1, 8'd0, 4'h1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [ROWS-1:0] row_mask = '0;
    logic [7:0]      trp_cycles = '0;
    logic [7:0]      trc_cycles = '0;
    logic [ROWS-1:0] cs_n;
    logic            ras_n, cas_n, we_n;
    logic [AW-1:0]   addr;
    logic            refresh_en, done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    logic [ROWS-1:0] e_cs   [MAXLEN];
    logic [2:0]      e_pins [MAXLEN];
    logic [AW-1:0]   e_addr [MAXLEN];
    logic            e_ref  [MAXLEN];
    logic            e_done [MAXLEN];
    string           e_tag  [MAXLEN];
    int              e_len;

    sdram_init_seq #(
        .NUM_ROWS (ROWS),
        .ADDR_W   (AW),
        .T_W      (8),
        .CLK_KHZ  (1000),
        .PWR_US   (40),
        .NOP_WAIT (NOPW)
    ) i_sdram_init_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .row_mask   (row_mask),
        .trp_cycles (trp_cycles),
        .trc_cycles (trc_cycles),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .refresh_en (refresh_en),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            miscompares = miscompares + 1;
            $display("FAIL R7 watchdog: got cycle %0d, expected completion before 60000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic push(input logic [ROWS-1:0] cs, input logic [2:0] p,
                        input logic [AW-1:0] a, input logic r, input logic d,
                        input string tag);
        e_cs[e_len]   = cs;
        e_pins[e_len] = p;
        e_addr[e_len] = a;
        e_ref[e_len]  = r;
        e_done[e_len] = d;
        e_tag[e_len]  = tag;
        e_len = e_len + 1;
    endtask

    // One step: a command per populated row, then NOP over the wait (R3, R5)
    task automatic add_step(input logic [ROWS-1:0] m, input logic [2:0] p,
                            input logic [AW-1:0] a, input int w, input string tag);
        for (int r = 0; r < ROWS; r++)
            if (m[r]) push(~(ROWS'(1) << r), p, a, 1'b0, 1'b0, tag);
        for (int k = 0; k < ((w == 0) ? 1 : w); k++)
            push(~m, 3'b111, '0, 1'b0, 1'b0, "R5");
    endtask

    task automatic build(input logic [ROWS-1:0] m, input int trp, input int trc);
        e_len = 0;
        for (int k = 0; k < PWR_CYC; k++) push('1, 3'b111, '0, 1'b0, 1'b0, "R2");
        add_step(m, 3'b111, '0, NOPW, "R3");
        add_step(m, 3'b010, 13'h400, trp, "R4");           // precharge-all
        for (int c = 0; c < 8; c++) add_step(m, 3'b001, '0, trc, "R4");
        add_step(m, 3'b000, 13'h198, 2, "R6");             // mode word << 3
        push('1, 3'b111, '0, 1'b0, 1'b0, "R7");
        push('1, 3'b111, '0, 1'b1, 1'b0, "R7");
        push('1, 3'b111, '0, 1'b1, 1'b1, "R7");
    endtask

    task automatic compare(input logic [ROWS-1:0] cs, input logic [2:0] p,
                           input logic [AW-1:0] a, input logic r, input logic d,
                           input string tag, input int t);
        vectors = vectors + 1;
        if (cs_n !== cs || {ras_n, cas_n, we_n} !== p || addr !== a ||
            refresh_en !== r || done !== d) begin
            miscompares = miscompares + 1;
            $display("FAIL %s cycle %0d: got cs=%b cmd=%b addr=%h ref=%b done=%b, expected cs=%b cmd=%b addr=%h ref=%b done=%b",
                     tag, t, cs_n, {ras_n, cas_n, we_n}, addr, refresh_en, done,
                     cs, p, a, r, d);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare('1, 3'b111, '0, 1'b0, 1'b0, "R1", -1);  // R1 idle after reset
    endtask

    initial begin
        @(negedge clk);
        compare('1, 3'b111, '0, 1'b0, 1'b0, "R1", -1);  // R1 during reset

        for (int v = 0; v < NVEC; v++) begin
            logic [ROWS-1:0] m;
            logic disturb;
            m       = VECS[v][23:20];
            disturb = VECS[v][0];
            do_reset();
            repeat (5) @(negedge clk);
            compare('1, 3'b111, '0, 1'b0, 1'b0, "R1", -1);  // R1 no start, stays idle
            build(m, int'(VECS[v][19:12]), int'(VECS[v][11:4]));
            row_mask   = m;
            trp_cycles = VECS[v][19:12];
            trc_cycles = VECS[v][11:4];
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < e_len; t++) begin
                compare(e_cs[t], e_pins[t], e_addr[t], e_ref[t], e_done[t], e_tag[t], t);
                if (disturb) begin
                    if (t == 3) row_mask = ~m;     // R8 late mask change ignored
                    if (t == 5) start = 1'b1;      // R9 start while busy ignored
                    if (t == 6) start = 1'b0;
                end
                @(negedge clk);
            end
            // R9 start after done ignored; R7 flags stay high
            start = 1'b1;
            for (int k = 0; k < 5; k++) begin
                compare('1, 3'b111, '0, 1'b1, 1'b1, "R9", e_len + k);
                @(negedge clk);
                start = 1'b0;
            end
        end

        // R1 reset in the middle of a sequence
        do_reset();
        row_mask   = 4'b1111;
        trp_cycles = 8'd3;
        trc_cycles = 8'd3;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        compare(4'b0000, 3'b111, '0, 1'b0, 1'b0, "R5", 100);  // inside NOP wait
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        compare('1, 3'b111, '0, 1'b0, 1'b0, "R1", -1);
        repeat (60) @(negedge clk);
        compare('1, 3'b111, '0, 1'b0, 1'b0, "R1", -1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule